// File: doc/BRIEF.md
# Prefixed Rotate/Shift/Swap Unit

This block is a purely combinational execution unit for the second byte of a prefixed 8-bit instruction. The upper bits of the opcode select one of eight operations: circular rotate left or right, rotate left or right through carry, arithmetic shift left, sign-keeping shift right, nibble exchange, and logical shift right. The lowest three bits name the destination register. The unit returns the new operand value and a fresh flag byte.

The surrounding core supplies the operand it read from its register file and its current flag byte, whose carry bit feeds the through-carry rotates. It writes the result and flags back in the same cycle. Opcodes outside the shift/rotate range raise an out-of-range indication. The operand and flags then pass through unchanged, so the core can route those opcodes elsewhere.

Top module: `rss_unit`

## Requirements
- R1: `dest_idx` always equals `op_code[2:0]`, for every opcode value.
- R2: Opcodes 0x00..0x07 rotate left circularly: result = {operand[6:0], operand[7]}, and the new carry = operand[7].
- R3: Opcodes 0x08..0x0F rotate right circularly: result = {operand[0], operand[7:1]}, and the new carry = operand[0].
- R4: Opcodes 0x10..0x17 rotate left through carry: result = {operand[6:0], old carry}, and the new carry = operand[7]. The old carry is `flags_in[4]`.
- R5: Opcodes 0x18..0x1F rotate right through carry: result = {old carry, operand[7:1]}, and the new carry = operand[0].
- R6: Opcodes 0x20..0x27 shift left with 0 into bit 0, and the new carry = operand[7]. Z is therefore set exactly when operand[6:0] is zero.
- R7: Opcodes 0x28..0x2F shift right with bit 7 kept in place, and the new carry = operand[0].
- R8: Opcodes 0x30..0x37 exchange the two nibbles of the operand, and the new carry is always 0.
- R9: Opcodes 0x38..0x3F shift right with 0 into bit 7, and the new carry = operand[0].
- R10: For opcodes below 0x40, `flags_out` is packed as Z in bit 7, N in bit 6, H in bit 5 and C in bit 4, with bits 3..0 at 0. Z = (result == 0), N = 0 and H = 0.
- R11: `out_of_range` is 1 exactly when op_code >= 0x40. In that case result = operand and flags_out = flags_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 8 | Second opcode byte of the prefixed instruction |
| operand | input | 8 | Value to rotate, shift or swap |
| flags_in | input | 8 | Current flag byte; bit 4 is the incoming carry |
| result | output | 8 | Produced operand value |
| dest_idx | output | 3 | Destination register index |
| flags_out | output | 8 | New flag byte |
| out_of_range | output | 1 | Opcode is outside this unit's range |

## Verification
Some properties are checked continuously on every input change: the destination index follows the opcode, Z agrees with the produced result, the unused flag bits stay low, and out-of-range opcodes pass the operand and flags through. Several per-operation invariants are also checked all the time: the sign bit survives the right arithmetic shift, the nibbles move on a swap, and the old carry enters bit 0 on a rotate left through carry. The exact data movement and carry source of each of the eight operations is shown only by the bench. It sweeps every opcode against edge operands (zero, single-bit, all-ones, sign-set patterns) with the carry both set and clear. Those scenarios also separate the circular rotates from the through-carry rotates, and the arithmetic shifts from the logical ones.

// File: rtl/rss_pkg.sv
// Shared types and flag layout for the rotate/shift/swap unit.
// Assumes an 8-bit flag byte with the four live flags in the upper nibble.
package rss_pkg;

    typedef enum logic [2:0] {
        OP_ROT_L_CIRC  = 3'd0,
        OP_ROT_R_CIRC  = 3'd1,
        OP_ROT_L_CARRY = 3'd2,
        OP_ROT_R_CARRY = 3'd3,
        OP_SHIFT_L     = 3'd4,
        OP_SHIFT_R_ARI = 3'd5,
        OP_NIB_SWAP    = 3'd6,
        OP_SHIFT_R_LOG = 3'd7
    } rss_op_e;

    localparam int FLAG_W  = 8;
    localparam int FLAG_ZB = 7;
    localparam int FLAG_NB = 6;
    localparam int FLAG_HB = 5;
    localparam int FLAG_CB = 4;

endpackage

// File: rtl/rss_decode.sv
// Opcode decoder: splits the opcode into operation group, destination
// index and out-of-range indication. Assumes the group field sits directly
// above the index field and that any bit above the group field is out of range.
module rss_decode
    import rss_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int OPC_W = 8
) (
    input  logic [OPC_W-1:0] op_code,
    output rss_op_e          op_sel,
    output logic [IDX_W-1:0] dest_idx,
    output logic             out_of_range
);

    localparam int GRP_LO = IDX_W;
    localparam int GRP_HI = IDX_W + 2;

    // Field extraction from the opcode byte.
    always_comb begin
        dest_idx     = op_code[IDX_W-1:0];
        op_sel       = rss_op_e'(op_code[GRP_HI:GRP_LO]);
        out_of_range = |op_code[OPC_W-1:GRP_HI+1];
    end

endmodule

// File: rtl/rss_datapath.sv
// Data path: produces the shifted/rotated/swapped value and the new carry
// for the selected operation. Assumes an even data width for the nibble swap.
module rss_datapath
    import rss_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rss_op_e           op_sel,
    input  logic [DATA_W-1:0] operand,
    input  logic              carry_in,
    output logic [DATA_W-1:0] shifted,
    output logic              carry_out
);

    localparam int MSB  = DATA_W - 1;
    localparam int HALF = DATA_W / 2;

    // Per-operation result and carry selection.
    always_comb begin
        shifted   = operand;
        carry_out = 1'b0;
        unique case (op_sel)
            OP_ROT_L_CIRC: begin
                shifted   = {operand[MSB-1:0], operand[MSB]};
                carry_out = operand[MSB];
            end
            OP_ROT_R_CIRC: begin
                shifted   = {operand[0], operand[MSB:1]};
                carry_out = operand[0];
            end
            OP_ROT_L_CARRY: begin
                shifted   = {operand[MSB-1:0], carry_in};
                carry_out = operand[MSB];
            end
            OP_ROT_R_CARRY: begin
                shifted   = {carry_in, operand[MSB:1]};
                carry_out = operand[0];
            end
            OP_SHIFT_L: begin
                shifted   = {operand[MSB-1:0], 1'b0};
                carry_out = operand[MSB];
            end
            OP_SHIFT_R_ARI: begin
                shifted   = {operand[MSB], operand[MSB:1]};
                carry_out = operand[0];
            end
            OP_NIB_SWAP: begin
                shifted   = {operand[HALF-1:0], operand[MSB:HALF]};
                carry_out = 1'b0;
            end
            OP_SHIFT_R_LOG: begin
                shifted   = {1'b0, operand[MSB:1]};
                carry_out = operand[0];
            end
            default: begin
                shifted   = operand;
                carry_out = 1'b0;
            end
        endcase
    end

    // Per-operation invariants on the produced value.
    always_comb begin
        if (op_sel == OP_SHIFT_R_ARI)
            assert_sign_kept_R7: assert (shifted[MSB] == operand[MSB]);
        if (op_sel == OP_NIB_SWAP)
            assert_nibble_move_R8: assert (shifted[HALF-1:0] == operand[MSB:HALF] && !carry_out);
        if (op_sel == OP_ROT_L_CARRY)
            assert_old_carry_R4: assert (shifted[0] == carry_in);
    end

endmodule

// File: rtl/rss_flags.sv
// Flag builder: packs zero, subtract, half-carry and carry into the flag byte.
// Assumes the subtract and half-carry flags are always cleared by this unit.
module rss_flags
    import rss_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] shifted,
    input  logic              carry_out,
    output logic [FLAG_W-1:0] flags_new
);

    // Flag byte assembly from the produced value.
    always_comb begin
        flags_new          = '0;
        flags_new[FLAG_ZB] = (shifted == '0);
        flags_new[FLAG_NB] = 1'b0;
        flags_new[FLAG_HB] = 1'b0;
        flags_new[FLAG_CB] = carry_out;
    end

endmodule

// File: rtl/rss_unit.sv
// Top of the prefixed rotate/shift/swap unit. Purely combinational: the
// core presents opcode, operand and flags and takes the result in the same
// cycle. Out-of-range opcodes pass operand and flags through untouched.
module rss_unit
    import rss_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3,
    localparam int OPC_W = IDX_W + 5
) (
    input  logic [OPC_W-1:0]  op_code,
    input  logic [DATA_W-1:0] operand,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [DATA_W-1:0] result,
    output logic [IDX_W-1:0]  dest_idx,
    output logic [FLAG_W-1:0] flags_out,
    output logic              out_of_range
);

    rss_op_e           op_sel;
    logic [DATA_W-1:0] shifted;
    logic              carry_out;
    logic [FLAG_W-1:0] flags_new;

    rss_decode #(.IDX_W(IDX_W), .OPC_W(OPC_W)) u_decode (
        .op_code      (op_code),
        .op_sel       (op_sel),
        .dest_idx     (dest_idx),
        .out_of_range (out_of_range)
    );

    rss_datapath #(.DATA_W(DATA_W)) u_datapath (
        .op_sel    (op_sel),
        .operand   (operand),
        .carry_in  (flags_in[FLAG_CB]),
        .shifted   (shifted),
        .carry_out (carry_out)
    );

    rss_flags #(.DATA_W(DATA_W)) u_flags (
        .shifted   (shifted),
        .carry_out (carry_out),
        .flags_new (flags_new)
    );

    // Output selection between computed values and pass-through.
    always_comb begin
        if (out_of_range) begin
            result    = operand;
            flags_out = flags_in;
        end else begin
            result    = shifted;
            flags_out = flags_new;
        end
    end

    // Cross-module consistency checks at the ports.
    always_comb begin
        assert_dest_R1: assert (dest_idx == op_code[IDX_W-1:0]);
        assert_range_R11: assert (out_of_range == (op_code >= OPC_W'(64)));
        if (out_of_range)
            assert_bypass_R11: assert (result == operand && flags_out == flags_in);
        else begin
            assert_zero_R10: assert (flags_out[FLAG_ZB] == (result == '0));
            assert_low_clear_R10: assert (flags_out[3:0] == 4'b0 && !flags_out[FLAG_NB] && !flags_out[FLAG_HB]);
        end
    end

endmodule

// File: tb/rss_unit_tb.sv
module rss_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic [7:0] operand = 8'h00;
    logic [7:0] flags_in = 8'h00;
    logic [7:0] result;
    logic [2:0] dest_idx;
    logic [7:0] flags_out;
    logic       out_of_range;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    rss_unit u_dut (
        .op_code      (op_code),
        .operand      (operand),
        .flags_in     (flags_in),
        .result       (result),
        .dest_idx     (dest_idx),
        .flags_out    (flags_out),
        .out_of_range (out_of_range)
    );

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic string tag_of(int opc);
        if (opc >= 64) return "R11";
        case (opc / 8)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s %s act=%02h exp=%02h", tag, what, act, exp);
        end
    endtask

    // Behavioural model of one vector, then comparison at the negedge.
    task automatic run_vec(int opc, int v, int fin);
        int cin, res, c, fexp;
        string tg;
        @(posedge clk);
        #1;
        op_code = opc[7:0];
        operand = v[7:0];
        flags_in = fin[7:0];
        cin = (fin >> 4) & 1;
        res = v;
        c = 0;
        case (opc / 8)
            0: begin res = ((v * 2) % 256) + v / 128; c = v / 128; end
            1: begin res = v / 2 + (v % 2) * 128; c = v % 2; end
            2: begin res = ((v * 2) % 256) + cin; c = v / 128; end
            3: begin res = v / 2 + cin * 128; c = v % 2; end
            4: begin res = (v * 2) % 256; c = v / 128; end
            5: begin res = v / 2 + (v / 128) * 128; c = v % 2; end
            6: begin res = (v % 16) * 16 + v / 16; c = 0; end
            7: begin res = v / 2; c = v % 2; end
            default: begin res = v; end
        endcase
        if (opc >= 64) fexp = fin;
        else fexp = (res == 0 ? 128 : 0) + c * 16;
        tg = tag_of(opc);
        @(negedge clk);
        check(tg, "result", int'(result), res);
        check(opc >= 64 ? "R11" : "R10", "flags", int'(flags_out), fexp);
        check("R1", "dest", int'(dest_idx), opc % 8);
        check("R11", "range", int'(out_of_range), opc >= 64 ? 1 : 0);
        if (opc / 8 == 4)
            check("R6", "z_low7", int'(flags_out[7]), (v % 128) == 0 ? 1 : 0);
    endtask

    initial begin
        int ops[9] = '{8'h00, 8'h01, 8'h80, 8'h81, 8'h7F, 8'hFF, 8'hA5, 8'h3C, 8'h40};
        int fl[4]  = '{8'h00, 8'hF0, 8'h10, 8'hEF};
        // Reset state: opcode 0 with a zero operand gives zero and Z only.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "reset flags", int'(flags_out), 8'h80);
        check("R2", "reset result", int'(result), 0);
        rst_n = 1'b1;
        for (int o = 0; o < 72; o++)
            for (int i = 0; i < 9; i++)
                for (int f = 0; f < 4; f++)
                    run_vec(o, ops[i], fl[f]);
        // Top of opcode space.
        run_vec(8'hFF, 8'h5A, 8'hB7);
        run_vec(8'hC3, 8'h00, 8'h00);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule